// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block keeps the tag, valid and dirty bits of an N-way set-associative cache and classifies every lookup. A request carries a physical address and a write flag. Atomic operations drive the write flag too. The controller picks a set from the address and compares the tag with every way of that set. It then updates the line state and reports one of four outcomes on a two-bit code: hit, fill of an empty way, clean eviction, or eviction of a dirty line that needs writing back. A tree-based pseudo-LRU unit, one tree per set, chooses the way to replace.

Three plain command pins act on all sets in a single cycle. Flush clears every dirty bit. Invalidate clears every valid bit. Restart clears the valid bits and the replacement trees together, which prepares the cache for a new run. Data arrays, bus traffic and the writeback itself belong to the surrounding cache.

Requests use a valid/ready handshake. The requester holds `req_valid`, `req_addr` and `req_write` stable until a cycle in which `req_ready` is high. `req_ready` drops during reset and in any cycle where a command pin is high. Results have no back-pressure: the consumer must take each `rsp_valid` pulse.

Top module: `cache_tag_ctrl`

## Requirements
- R1: The address is split as offset = low OFF_W bits, set = next SET_W bits and tag = next TAG_W bits. With the defaults these are bits [5:0], [7:6] and [15:8]. The offset never changes the outcome.
- R2: A lookup hits when a valid way of the set holds the tag. It reports code 00, and that line's dirty bit becomes its old value OR the write flag.
- R3: On a miss with at least one invalid way, the lowest-numbered invalid way receives the tag. That way becomes valid, its dirty bit equals the write flag, and the code is 01.
- R4: On a miss with every way valid, the pseudo-LRU victim receives the tag. It becomes valid with dirty equal to the write flag. The code is 11 if the victim was dirty before replacement and 10 otherwise.
- R5: Each set keeps a binary tree of WAYS-1 bits in heap order. Every hit or fill makes the nodes on the path of the accessed way point away from it. The victim is found by walking from the root, where bit 0 selects the lower half and bit 1 the upper half.
- R6: Flush clears the dirty bit of every line in all sets and leaves valid bits unchanged.
- R7: Invalidate clears the valid bit of every line in all sets, so an earlier resident tag then misses.
- R8: Restart clears all valid bits and all replacement trees in one cycle.
- R9: `req_ready` is low during reset and in any cycle where a command pin is high. An accepted request produces a `rsp_valid` pulse of exactly one cycle, in the following cycle, with the code on `rsp_code`.
- R10: After reset the cache is empty, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_addr | input | PA_W | Physical address of the lookup |
| req_write | input | 1 | Store or atomic access; sets the line dirty |
| cmd_flush | input | 1 | Clear all dirty bits |
| cmd_inval | input | 1 | Clear all valid bits |
| cmd_restart | input | 1 | Clear all valid bits and replacement trees |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_code | output | 2 | 00 hit, 01 fill, 10 clean eviction, 11 dirty eviction |

## Verification
Assertions check several rules on every cycle. They cover the handshake and strobe timing, ready being blocked by commands, and a tag matching in at most one way. They also check that each command clears the state it owns while flush keeps the valid bits, that an eviction always yields an eviction code, and that a touched way is never the next victim. Other behaviour shows only through the bench's scripted access streams. That covers the actual victim order, dirty bits surviving or being cleared and then showing up as clean or dirty evictions, independence between sets, and fills after an invalidate or restart.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

  typedef enum logic [1:0] {
    OUT_HIT   = 2'b00,
    OUT_FILL  = 2'b01,
    OUT_EVICT = 2'b10,
    OUT_DIRTY = 2'b11
  } outcome_e;

endpackage

// File: rtl/ctc_way_lookup.sv
module ctc_way_lookup #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WAYS-1:0][TAG_W-1:0]  set_tags,
  input  logic [WAYS-1:0]             set_valid,
  input  logic [TAG_W-1:0]            look_tag,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way,
  output logic                        free_any,
  output logic [WAY_W-1:0]            free_way
);

  logic [WAYS-1:0] match_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_vec[w] = set_valid[w] && (set_tags[w] == look_tag);
  end

  always_comb begin
    hit      = |match_vec;
    free_any = ~&set_valid;
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_vec[w])  hit_way  = WAY_W'(w);
      if (!set_valid[w]) free_way = WAY_W'(w);
    end
  end

  // R2
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

endmodule

// File: rtl/ctc_plru.sv
module ctc_plru #(
  parameter int SETS = 4,
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS),
  localparam int NODES = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_set,
  input  logic [WAY_W-1:0] upd_way,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAY_W-1:0] victim
);

  logic [NODES-1:0] tree_q [SETS];
  logic             tree_any;

  function automatic logic [WAY_W-1:0] pick_way(input logic [NODES-1:0] t);
    int idx = 0;
    for (int l = 0; l < WAY_W; l++) idx = 2 * idx + 1 + int'(t[idx]);
    return WAY_W'(idx - NODES);
  endfunction

  function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] t,
                                             input logic [WAY_W-1:0] w);
    logic [NODES-1:0] r = t;
    int idx = NODES + int'(w);
    for (int l = 0; l < WAY_W; l++) begin
      int par = (idx - 1) / 2;
      r[par] = (idx % 2) == 1;
      idx = par;
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (upd_en) begin
      tree_q[upd_set] <= touch(tree_q[upd_set], upd_way);
    end
  end

  assign victim = pick_way(tree_q[rd_set]);

  always_comb begin
    tree_any = 1'b0;
    for (int s = 0; s < SETS; s++) tree_any = tree_any | (|tree_q[s]);
  end

  // R5
  touched_not_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !clear) |=> pick_way(tree_q[$past(upd_set)]) != $past(upd_way));

  // R8
  tree_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !tree_any);

endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
  import cache_tag_pkg::*;
#(
  parameter int LINES = 16,
  parameter int WAYS  = 4,
  parameter int PA_W  = 16,
  parameter int TAG_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [PA_W-1:0] req_addr,
  input  logic            req_write,
  input  logic            cmd_flush,
  input  logic            cmd_inval,
  input  logic            cmd_restart,
  output logic            rsp_valid,
  output logic [1:0]      rsp_code
);

  localparam int SETS  = LINES / WAYS;
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int OFF_W = PA_W - TAG_W - SET_W;

  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [WAYS-1:0]            valid_q [SETS];
  logic [WAYS-1:0]            dirty_q [SETS];

  logic [TAG_W-1:0] req_tag;
  logic [SET_W-1:0] req_set;
  logic             any_cmd, fire;
  logic             hit, free_any;
  logic [WAY_W-1:0] hit_way, free_way, victim, tgt_way;
  outcome_e         outcome;

  assign req_tag  = req_addr[OFF_W+SET_W +: TAG_W];
  assign req_set  = req_addr[OFF_W +: SET_W];
  assign any_cmd  = cmd_flush | cmd_inval | cmd_restart;
  assign req_ready = rst_n & ~any_cmd;
  assign fire     = req_valid & req_ready;

  ctc_way_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) i_lookup (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_tags (tag_q[req_set]),
    .set_valid(valid_q[req_set]),
    .look_tag (req_tag),
    .hit      (hit),
    .hit_way  (hit_way),
    .free_any (free_any),
    .free_way (free_way)
  );

  ctc_plru #(.SETS(SETS), .WAYS(WAYS)) i_plru (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (cmd_restart),
    .upd_en (fire),
    .upd_set(req_set),
    .upd_way(tgt_way),
    .rd_set (req_set),
    .victim (victim)
  );

  always_comb begin
    if (hit) begin
      outcome = OUT_HIT;
      tgt_way = hit_way;
    end else if (free_any) begin
      outcome = OUT_FILL;
      tgt_way = free_way;
    end else begin
      tgt_way = victim;
      outcome = dirty_q[req_set][victim] ? OUT_DIRTY : OUT_EVICT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
      rsp_valid <= 1'b0;
      rsp_code  <= OUT_HIT;
    end else begin
      rsp_valid <= fire;
      if (fire) rsp_code <= outcome;
      for (int s = 0; s < SETS; s++) begin
        if (cmd_inval || cmd_restart) valid_q[s] <= '0;
        if (cmd_flush)                dirty_q[s] <= '0;
      end
      if (fire) begin
        valid_q[req_set][tgt_way] <= 1'b1;
        dirty_q[req_set][tgt_way] <= hit ? (dirty_q[req_set][tgt_way] | req_write)
                                         : req_write;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fire && !hit) tag_q[req_set][tgt_way] <= req_tag;
  end

  logic [SETS*WAYS-1:0] valid_flat, dirty_flat;
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      valid_flat[s*WAYS +: WAYS] = valid_q[s];
      dirty_flat[s*WAYS +: WAYS] = dirty_q[s];
    end
  end

  // R9
  rsp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rsp_valid == $past(fire)));

  // R9
  cmd_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_cmd |-> !req_ready);

  // R6
  flush_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_flush |=> (dirty_flat == '0));

  // R6
  flush_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_flush && !cmd_inval && !cmd_restart) |=> $stable(valid_flat));

  // R7
  inval_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_inval || cmd_restart) |=> (valid_flat == '0));

  // R4
  evict_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !hit && !free_any) |=> rsp_code[1]);

  // R3
  fill_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !hit && free_any) |=>
      ($countones(valid_flat) == $countones($past(valid_flat)) + 1));

endmodule

// File: tb/test_cache_tag_ctrl.sv
module test_cache_tag_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        cmd_flush = 1'b0, cmd_inval = 1'b0, cmd_restart = 1'b0;
  logic        rsp_valid;
  logic [1:0]  rsp_code;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  cache_tag_ctrl #(.LINES(16), .WAYS(4), .PA_W(16), .TAG_W(8)) i_cache_tag_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .cmd_flush(cmd_flush),
    .cmd_inval(cmd_inval), .cmd_restart(cmd_restart),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code)
  );

  // entry: op[20:19] (0 req, 1 flush, 2 inval, 3 restart), write[18],
  // tag[17:10], set[9:8], offset[7:2], expected code[1:0]
  localparam int NV = 35;
  localparam logic [20:0] VEC [NV] = '{
    {2'd0,1'b0,8'h21,2'd2,6'd0,2'd1},  // set 2 fill
    {2'd0,1'b0,8'h22,2'd2,6'd0,2'd1},
    {2'd0,1'b0,8'h23,2'd2,6'd0,2'd1},
    {2'd0,1'b0,8'h24,2'd2,6'd0,2'd1},
    {2'd0,1'b1,8'h21,2'd2,6'd5,2'd0},  // write hit dirties way 0
    {2'd0,1'b0,8'h25,2'd2,6'd0,2'd2},
    {2'd0,1'b0,8'h26,2'd2,6'd0,2'd2},
    {2'd0,1'b0,8'h27,2'd2,6'd0,2'd2},
    {2'd0,1'b0,8'h28,2'd2,6'd0,2'd3},  // way 0 dirty from hit
    {2'd0,1'b0,8'h11,2'd0,6'd0,2'd1},  // set 0 fill
    {2'd0,1'b1,8'h12,2'd0,6'd0,2'd1},
    {2'd0,1'b0,8'h13,2'd0,6'd0,2'd1},
    {2'd0,1'b0,8'h14,2'd0,6'd0,2'd1},
    {2'd0,1'b0,8'h11,2'd0,6'h3f,2'd0}, // offset ignored
    {2'd0,1'b0,8'h15,2'd0,6'd0,2'd2},  // victim way 2
    {2'd0,1'b0,8'h16,2'd0,6'd0,2'd3},  // victim way 1 dirty
    {2'd0,1'b1,8'h14,2'd0,6'd0,2'd0},
    {2'd1,1'b0,8'h00,2'd0,6'd0,2'd0},  // flush
    {2'd0,1'b0,8'h14,2'd0,6'd0,2'd0},  // still valid
    {2'd0,1'b0,8'h17,2'd0,6'd0,2'd2},
    {2'd0,1'b0,8'h18,2'd0,6'd0,2'd2},
    {2'd0,1'b0,8'h19,2'd0,6'd0,2'd2},
    {2'd0,1'b0,8'h1a,2'd0,6'd0,2'd2},  // flushed line leaves clean
    {2'd0,1'b1,8'h11,2'd1,6'd0,2'd1},  // set 1 independent
    {2'd0,1'b1,8'h11,2'd1,6'd0,2'd0},
    {2'd2,1'b0,8'h00,2'd0,6'd0,2'd0},  // invalidate
    {2'd0,1'b0,8'h1a,2'd0,6'd0,2'd1},
    {2'd0,1'b0,8'h19,2'd0,6'd0,2'd1},
    {2'd0,1'b0,8'h12,2'd0,6'd0,2'd1},
    {2'd0,1'b0,8'h13,2'd0,6'd0,2'd1},
    {2'd0,1'b0,8'h14,2'd0,6'd0,2'd2},
    {2'd3,1'b0,8'h00,2'd0,6'd0,2'd0},  // restart
    {2'd0,1'b1,8'h11,2'd0,6'd0,2'd1},
    {2'd0,1'b0,8'h11,2'd0,6'd0,2'd0},
    {2'd0,1'b1,8'h11,2'd1,6'd0,2'd1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] code);
    case (code)
      2'd0:    return "R2 hit";
      2'd1:    return "R3 fill";
      default: return "R4 R5 eviction";
    endcase
  endfunction

  task automatic do_req(input logic [7:0] tag, input logic [1:0] set,
                        input logic [5:0] off, input logic wr, input logic [1:0] exp);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = {tag, set, off};
    req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, "R9 strobe", int'(rsp_valid), 1);
    check(rsp_code == exp, req_of(exp), int'(rsp_code), int'(exp));
  endtask

  task automatic do_cmd(input logic [1:0] op);
    @(negedge clk);
    cmd_flush   = (op == 2'd1);
    cmd_inval   = (op == 2'd2);
    cmd_restart = (op == 2'd3);
    @(negedge clk);
    cmd_flush = 1'b0; cmd_inval = 1'b0; cmd_restart = 1'b0;
    check(rsp_valid == 1'b0, "R6 R7 R8 command no strobe", int'(rsp_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 / R9: not ready during reset
    check(req_ready == 1'b0, "R9 ready in reset", int'(req_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R10 ready after reset", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R10 no strobe after reset", int'(rsp_valid), 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20:19] == 2'd0)
        do_req(VEC[i][17:10], VEC[i][9:8], VEC[i][7:2], VEC[i][18], VEC[i][1:0]);
      else
        do_cmd(VEC[i][20:19]);
    end

    // R9: request held while a command is high is not accepted
    @(negedge clk);
    req_valid = 1'b1; req_addr = {8'h31, 2'd3, 6'd0}; req_write = 1'b0;
    cmd_flush = 1'b1;
    #1 check(req_ready == 1'b0, "R9 ready low with command", int'(req_ready), 0);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9 blocked request no strobe", int'(rsp_valid), 0);
    cmd_flush = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1 && rsp_code == 2'd1, "R9 held request fills",
          int'({rsp_valid, rsp_code}), 5);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9 strobe lasts one cycle", int'(rsp_valid), 0);
    // R1: same tag and set, other offset, hits
    do_req(8'h31, 2'd3, 6'd33, 1'b0, 2'd0);

    // R10: reset empties the cache
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_req(8'h31, 2'd3, 6'd0, 1'b0, 2'd1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule